// File: doc/BRIEF.md
# Ring Descriptor Frame Mover

This block carries Ethernet frames between a shared word-addressed memory and two byte streams that face a MAC. Each direction walks its own ring of 16-byte descriptors. A descriptor has four 32-bit words: word 0 holds control and status, word 1 holds lengths, word 2 holds the buffer address, and word 3 is spare. Descriptors sit back to back, so the stride is 16 bytes. The host passes a descriptor to the engine by setting the ownership bit, bit 31 of word 0. The engine passes it back by clearing that bit once it has finished with the descriptor.

The transmit walker reads a descriptor it owns and streams the buffer bytes out in little-endian order, taking byte 0 from bits 7:0 of the first word. It then writes word 0 back with the ownership bit cleared. The receive walker fills the buffer of a descriptor it owns from the incoming byte stream. It records the received byte count, error status and error summary, returns the descriptor, and pulses a frame-done output. Both walkers share one memory port through a small arbiter in which receive has priority. A start pulse sets a direction running. The direction keeps running until it meets a descriptor it does not own, and another start pulse resumes it from that same descriptor.

Top module: `ring_frame_mover`

## Requirements
- R1: After a synchronous reset, mem_req, tx_valid, tx_busy, rx_busy, rx_ready and rx_frame_done are all 0. Both ring pointers sit at their configured bases.
- R2: For each owned transmit descriptor, the walker emits L bytes from the word-aligned buffer address found in word 2, in little-endian order. L is word 1 bits 31:16. tx_last is 1 only on the final byte. A descriptor with L = 0 emits no bytes.
- R3: A transmit length above 1514 is cut to 1514 bytes.
- R4: After transmitting, the walker rewrites word 0 with bit 31 cleared. Every other bit of word 0, including the single-buffer pair at bits 29:28, keeps its value.
- R5: A walker that reads a word 0 with bit 31 clear stops and drops its busy output. It modifies nothing in that descriptor. The next start pulse re-reads that same descriptor.
- R6: After a descriptor whose word 0 bit 30 is set, the next descriptor is at the ring base. Otherwise the next descriptor is 16 bytes further on.
- R7: Received bytes are stored little-endian from the buffer address. In the final written word, the byte lanes past the stored count are 0. Word 1 is written back as the buffer length in bits 31:16, unchanged, and the stored byte count in bits 15:0.
- R8: When a frame is longer than the buffer length, only buffer-length bytes are stored and counted. Nothing is written past the buffer, and word 0 bit 25 (overflow) is set.
- R9: Receive word 0 is written back with these fields: bit 31 = 0; bit 30 kept from the descriptor; bit 27 = OR of bits 25:16; bit 25 = overflow. rx_flags[5:0] sampled with the last byte map to bits 22, 20, 19, 18, 17, 16 (address, residual, too long, too short, PHY error, CRC error), in that order from rx_flags[5] down to rx_flags[0]. All other bits are 0.
- R10: rx_frame_done is high for exactly one cycle after each receive word 0 write-back.
- R11: While the receive walker owns no descriptor, rx_ready stays 0 and incoming bytes are left waiting.
- R12: Both directions can run at once over the single memory port. Each request holds its address, direction and data until mem_ready, and both frames complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_ring_base | input | 32 | Byte address of the first transmit descriptor |
| rx_ring_base | input | 32 | Byte address of the first receive descriptor |
| tx_start | input | 1 | Pulse: start or resume the transmit walk |
| rx_start | input | 1 | Pulse: start or resume the receive walk |
| tx_busy | output | 1 | Transmit walk running |
| rx_busy | output | 1 | Receive walk running |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts the transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_flags | input | 6 | Frame error flags, sampled with rx_last |
| rx_ready | output | 1 | Walker accepts the receive byte |
| rx_frame_done | output | 1 | One-cycle pulse after a receive write-back |

## Verification
The case hardest to reach is the two walkers competing for the memory port while the memory answers with random latency. In that case the receive walker must hold a partial word across a transmit read without losing or reordering bytes. The stimulus starts a transmit frame and a receive frame in the same cycle. The memory grants requests randomly on about three cycles in four and the transmit sink stalls at random, so the requests overlap in many different orders. A frame that overflows its buffer, the wrap from a last descriptor back to the base, and a stop at an unowned descriptor are each produced by rewriting descriptors between runs.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  localparam int ADDR_W   = 32;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 16;
  localparam int FLAG_W   = 6;
  localparam int STRIDE   = 16;
  localparam int OWN_B    = 31;
  localparam int LAST_B   = 30;

  typedef enum logic [2:0] {
    T_IDLE, T_W0, T_W1, T_W2, T_RD, T_SEND, T_WB
  } tx_st_e;

  typedef enum logic [3:0] {
    R_IDLE, R_W0, R_W1, R_W2, R_RECV, R_WDAT, R_WLEN, R_WSTS, R_ADV
  } rx_st_e;

  function automatic logic [ADDR_W-1:0] next_desc(input logic [ADDR_W-1:0] cur,
                                                  input logic [ADDR_W-1:0] base,
                                                  input logic              wrap);
    return wrap ? base : cur + ADDR_W'(STRIDE);
  endfunction

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] len,
                                                 input logic [LEN_W-1:0] lim);
    return (len > lim) ? lim : len;
  endfunction

  function automatic logic [ADDR_W-1:0] word_off(input logic [LEN_W-1:0] n);
    return ADDR_W'({n[LEN_W-1:2], 2'b00});
  endfunction

  // status field: [9] overflow, [6] address, [4:0] residual/long/short/phy/crc
  function automatic logic [WORD_W-1:0] pack_status(input logic wrap, input logic ovf,
                                                    input logic [FLAG_W-1:0] fl);
    logic [9:0] fld;
    logic [WORD_W-1:0] w;
    fld = {ovf, 2'b00, fl[5], 1'b0, fl[4:0]};
    w = '0;
    w[LAST_B] = wrap;
    w[27]     = |fld;
    w[25:16]  = fld;
    return w;
  endfunction
endpackage

// File: rtl/rfm_mem_arb.sv
module rfm_mem_arb
  import rfm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_req,
  input  logic              hi_we,
  input  logic [ADDR_W-1:0] hi_addr,
  input  logic [WORD_W-1:0] hi_wdata,
  output logic              hi_done,
  input  logic              lo_req,
  input  logic              lo_we,
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [WORD_W-1:0] lo_wdata,
  output logic              lo_done,
  output logic              m_req,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [WORD_W-1:0] m_wdata,
  input  logic              m_ready
);
  logic held, held_lo, pick_lo;

  assign pick_lo = held ? held_lo : !hi_req;
  assign m_req   = pick_lo ? lo_req   : hi_req;
  assign m_we    = pick_lo ? lo_we    : hi_we;
  assign m_addr  = pick_lo ? lo_addr  : hi_addr;
  assign m_wdata = pick_lo ? lo_wdata : hi_wdata;
  assign hi_done = m_ready && !pick_lo;
  assign lo_done = m_ready &&  pick_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= 1'b0;
      held_lo <= 1'b0;
    end else if (m_ready) begin
      held <= 1'b0;
    end else if (m_req) begin
      held    <= 1'b1;
      held_lo <= pick_lo;
    end
  end

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)))
    else $error("memory request changed before ready");
endmodule

// File: rtl/rfm_tx_walker.sv
module rfm_tx_walker
  import rfm_pkg::*;
#(
  parameter int MAX_LEN = 1514
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              start,
  output logic              busy,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] rdata,
  input  logic              done,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready
);
  localparam logic [LEN_W-1:0] LIM = LEN_W'(MAX_LEN);

  tx_st_e            state;
  logic              run;
  logic [ADDR_W-1:0] cur, ptr;
  logic [WORD_W-1:0] w0, word;
  logic [LEN_W-1:0]  remain;
  logic [1:0]        lane;
  logic              beat;

  assign beat = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= T_IDLE;
      run    <= 1'b0;
      cur    <= ring_base;
      ptr    <= '0;
      w0     <= '0;
      word   <= '0;
      remain <= '0;
      lane   <= '0;
    end else begin
      if (start) run <= 1'b1;
      case (state)
        T_IDLE: if (run) state <= T_W0;
        T_W0: if (done) begin
          if (rdata[OWN_B]) begin
            w0    <= rdata;
            state <= T_W1;
          end else begin
            run   <= start;
            state <= T_IDLE;
          end
        end
        T_W1: if (done) begin
          remain <= clamp_len(rdata[31:16], LIM);
          state  <= T_W2;
        end
        T_W2: if (done) begin
          ptr   <= rdata & ~32'd3;
          lane  <= '0;
          state <= (remain == '0) ? T_WB : T_RD;
        end
        T_RD: if (done) begin
          word  <= rdata;
          state <= T_SEND;
        end
        T_SEND: if (tx_ready) begin
          remain <= remain - 1'b1;
          lane   <= lane + 1'b1;
          if (remain == LEN_W'(1)) state <= T_WB;
          else if (lane == 2'd3) begin
            ptr   <= ptr + 32'd4;
            state <= T_RD;
          end
        end
        T_WB: if (done) begin
          cur   <= next_desc(cur, ring_base, w0[LAST_B]);
          state <= T_W0;
        end
        default: state <= T_IDLE;
      endcase
    end
  end

  always_comb begin
    req   = 1'b0;
    we    = 1'b0;
    addr  = cur;
    wdata = w0 & ~(32'd1 << OWN_B);
    case (state)
      T_W0: req = 1'b1;
      T_W1: begin req = 1'b1; addr = cur + 32'd4; end
      T_W2: begin req = 1'b1; addr = cur + 32'd8; end
      T_RD: begin req = 1'b1; addr = ptr; end
      T_WB: begin req = 1'b1; we = 1'b1; end
      default: ;
    endcase
  end

  assign busy     = run;
  assign tx_valid = (state == T_SEND);
  assign tx_data  = word[{lane, 3'b000} +: 8];
  assign tx_last  = tx_valid && (remain == LEN_W'(1));

  // bytes emitted in the current frame, for the length cap check
  logic [LEN_W-1:0] sent;
  always_ff @(posedge clk) begin
    if (rst || state == T_W0) sent <= '0;
    else if (beat) sent <= sent + 1'b1;
  end

  p_len_cap_r3: assert property (@(posedge clk) disable iff (rst) sent <= LIM)
    else $error("transmit frame longer than limit");
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst) !busy |-> !tx_valid)
    else $error("bytes sent while stopped");
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)))
    else $error("transmit byte changed while stalled");
endmodule

// File: rtl/rfm_rx_walker.sv
module rfm_rx_walker
  import rfm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              start,
  output logic              busy,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] rdata,
  input  logic              done,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [FLAG_W-1:0] rx_flags,
  output logic              rx_ready,
  output logic              frame_done
);
  rx_st_e            state;
  logic              run, wrap, ovf, fin;
  logic [ADDR_W-1:0] cur, bptr, wr_addr;
  logic [LEN_W-1:0]  buflen, stored;
  logic [WORD_W-1:0] stage;
  logic [2:0]        stage_n;
  logic [FLAG_W-1:0] flags;
  logic              fits, take, flush;

  assign fits  = stored < buflen;
  assign take  = rx_ready && rx_valid;
  assign flush = (fits && stored[1:0] == 2'd3) || (rx_last && (fits || stage_n != 3'd0));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= R_IDLE;
      run     <= 1'b0;
      cur     <= ring_base;
      wrap    <= 1'b0;
      ovf     <= 1'b0;
      fin     <= 1'b0;
      bptr    <= '0;
      wr_addr <= '0;
      buflen  <= '0;
      stored  <= '0;
      stage   <= '0;
      stage_n <= '0;
      flags   <= '0;
    end else begin
      if (start) run <= 1'b1;
      case (state)
        R_IDLE: if (run) state <= R_W0;
        R_W0: if (done) begin
          if (rdata[OWN_B]) begin
            wrap  <= rdata[LAST_B];
            state <= R_W1;
          end else begin
            run   <= start;
            state <= R_IDLE;
          end
        end
        R_W1: if (done) begin
          buflen <= rdata[31:16];
          state  <= R_W2;
        end
        R_W2: if (done) begin
          bptr    <= rdata & ~32'd3;
          stored  <= '0;
          stage   <= '0;
          stage_n <= '0;
          ovf     <= 1'b0;
          fin     <= 1'b0;
          flags   <= '0;
          state   <= R_RECV;
        end
        R_RECV: if (take) begin
          if (fits) begin
            stage[{stored[1:0], 3'b000} +: 8] <= rx_data;
            stored  <= stored + 1'b1;
            stage_n <= stage_n + 1'b1;
            if (stage_n == 3'd0) wr_addr <= bptr + word_off(stored);
          end else begin
            ovf <= 1'b1;
          end
          if (rx_last) begin
            flags <= rx_flags;
            fin   <= 1'b1;
          end
          if (flush) state <= R_WDAT;
          else if (rx_last) state <= R_WLEN;
        end
        R_WDAT: if (done) begin
          stage   <= '0;
          stage_n <= '0;
          state   <= fin ? R_WLEN : R_RECV;
        end
        R_WLEN: if (done) state <= R_WSTS;
        R_WSTS: if (done) begin
          cur   <= next_desc(cur, ring_base, wrap);
          state <= R_ADV;
        end
        R_ADV: state <= R_W0;
        default: state <= R_IDLE;
      endcase
    end
  end

  always_comb begin
    req   = 1'b0;
    we    = 1'b0;
    addr  = cur;
    wdata = '0;
    case (state)
      R_W0: req = 1'b1;
      R_W1: begin req = 1'b1; addr = cur + 32'd4; end
      R_W2: begin req = 1'b1; addr = cur + 32'd8; end
      R_WDAT: begin req = 1'b1; we = 1'b1; addr = wr_addr; wdata = stage; end
      R_WLEN: begin req = 1'b1; we = 1'b1; addr = cur + 32'd4; wdata = {buflen, stored}; end
      R_WSTS: begin req = 1'b1; we = 1'b1; wdata = pack_status(wrap, ovf, flags); end
      default: ;
    endcase
  end

  assign busy       = run;
  assign rx_ready   = (state == R_RECV);
  assign frame_done = (state == R_ADV);

  p_count_fits_r8: assert property (@(posedge clk) disable iff (rst)
    (state == R_WLEN) |-> (stored <= buflen))
    else $error("stored count exceeds buffer length");
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done)
    else $error("frame done wider than one cycle");
  p_no_take_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rx_ready)
    else $error("accepting bytes while stopped");
endmodule

// File: rtl/ring_frame_mover.sv
module ring_frame_mover
  import rfm_pkg::*;
#(
  parameter int TX_MAX_LEN = 1514
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] tx_ring_base,
  input  logic [ADDR_W-1:0] rx_ring_base,
  input  logic              tx_start,
  input  logic              rx_start,
  output logic              tx_busy,
  output logic              rx_busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [FLAG_W-1:0] rx_flags,
  output logic              rx_ready,
  output logic              rx_frame_done
);
  logic              t_req, t_we, t_done, r_req, r_we, r_done;
  logic [ADDR_W-1:0] t_addr, r_addr;
  logic [WORD_W-1:0] t_wdata, r_wdata;

  rfm_tx_walker #(.MAX_LEN(TX_MAX_LEN)) u_tx (
    .clk(clk), .rst(rst), .ring_base(tx_ring_base), .start(tx_start), .busy(tx_busy),
    .req(t_req), .we(t_we), .addr(t_addr), .wdata(t_wdata), .rdata(mem_rdata), .done(t_done),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  rfm_rx_walker u_rx (
    .clk(clk), .rst(rst), .ring_base(rx_ring_base), .start(rx_start), .busy(rx_busy),
    .req(r_req), .we(r_we), .addr(r_addr), .wdata(r_wdata), .rdata(mem_rdata), .done(r_done),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_flags(rx_flags),
    .rx_ready(rx_ready), .frame_done(rx_frame_done)
  );

  rfm_mem_arb u_arb (
    .clk(clk), .rst(rst),
    .hi_req(r_req), .hi_we(r_we), .hi_addr(r_addr), .hi_wdata(r_wdata), .hi_done(r_done),
    .lo_req(t_req), .lo_we(t_we), .lo_addr(t_addr), .lo_wdata(t_wdata), .lo_done(t_done),
    .m_req(mem_req), .m_we(mem_we), .m_addr(mem_addr), .m_wdata(mem_wdata), .m_ready(mem_ready)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) $past(rst) |-> (!mem_req && !tx_valid && !rx_frame_done))
    else $error("activity right after reset");
endmodule

// File: tb/ring_frame_mover_tb.sv
module ring_frame_mover_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic [31:0] tx_ring_base = 32'h0000, rx_ring_base = 32'h0100;
  logic        tx_start = 0, rx_start = 0, tx_busy, rx_busy;
  logic        mem_req, mem_we, mem_ready = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_last, tx_ready = 0;
  logic [7:0]  tx_data;
  logic        rx_valid = 0, rx_last = 0, rx_ready, rx_frame_done;
  logic [7:0]  rx_data = 0;
  logic [5:0]  rx_flags = 0;

  always #5 clk = ~clk;

  ring_frame_mover u_dut (.*);

  logic [31:0] mem [0:4095];
  assign mem_rdata = mem[mem_addr[13:2]];

  int tests = 0, fails = 0, pulses = 0;
  logic [7:0] got_q[$], exp_q[$];
  logic       got_l[$], exp_l[$];
  logic [7:0] fr [0:4][0:255];

  localparam logic [31:0] TXB = 32'h1000, RXB = 32'h2A00, BUFSZ = 32'd1600;

  // memory model: grants randomly, writes take effect when granted
  initial forever begin
    @(negedge clk);
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_req && ($urandom % 4) != 0) begin
      mem_ready = 1'b1;
      if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
    end
  end

  initial forever begin
    @(negedge clk);
    tx_ready = ($urandom % 4) != 0;
    if (tx_valid && tx_ready) begin got_q.push_back(tx_data); got_l.push_back(tx_last); end
    if (rx_frame_done) pulses++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    logic [31:0] w = mem[a[13:2]];
    return w[a[1:0]*8 +: 8];
  endfunction

  task automatic wr_byte(input logic [31:0] a, input logic [7:0] b);
    logic [31:0] w = mem[a[13:2]];
    w[a[1:0]*8 +: 8] = b;
    mem[a[13:2]] = w;
  endtask

  function automatic int exp_tx_len(input int l);
    if (l > 1514) return 1514;
    return l;
  endfunction

  function automatic logic [31:0] exp_rx_w0(input bit last, input bit ovf, input logic [5:0] fl);
    logic [31:0] w = 0;
    if (last) w[30] = 1;
    if (fl[0]) w[16] = 1;
    if (fl[1]) w[17] = 1;
    if (fl[2]) w[18] = 1;
    if (fl[3]) w[19] = 1;
    if (fl[4]) w[20] = 1;
    if (fl[5]) w[22] = 1;
    if (ovf) w[25] = 1;
    if (ovf || fl != 0) w[27] = 1;
    return w;
  endfunction

  function automatic logic [31:0] tx_w0(input bit own, input bit last);
    return {own, last, 2'b11, 28'h0};
  endfunction

  task automatic tx_desc(input int i, input bit own, input bit last, input int len);
    logic [31:0] d = tx_ring_base + 32'(i * 16);
    mem[d[13:2]]     = tx_w0(own, last);
    mem[d[13:2] + 1] = {16'(len), 16'h0};
    mem[d[13:2] + 2] = TXB + 32'(i) * BUFSZ;
    mem[d[13:2] + 3] = 0;
  endtask

  task automatic rx_desc(input int i, input bit own, input bit last, input int blen);
    logic [31:0] d = rx_ring_base + 32'(i * 16);
    mem[d[13:2]]     = {own, last, 30'h0};
    mem[d[13:2] + 1] = {16'(blen), 16'h0};
    mem[d[13:2] + 2] = RXB + 32'(i) * BUFSZ;
    mem[d[13:2] + 3] = 0;
  endtask

  task automatic expect_tx(input int i, input int len);
    for (int k = 0; k < exp_tx_len(len); k++) begin
      exp_q.push_back(rd_byte(TXB + 32'(i) * BUFSZ + 32'(k)));
      exp_l.push_back(k == exp_tx_len(len) - 1);
    end
  endtask

  task automatic check_tx(input string req);
    int bad = -1;
    chk(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size()) begin
      for (int k = 0; k < exp_q.size(); k++)
        if (bad < 0 && (got_q[k] !== exp_q[k] || got_l[k] !== exp_l[k])) bad = k;
      if (bad >= 0) chk(0, {req, " byte/last"}, {got_l[bad], got_q[bad]}, {exp_l[bad], exp_q[bad]});
      else chk(1, req, 0, 0);
    end
    got_q.delete(); got_l.delete(); exp_q.delete(); exp_l.delete();
  endtask

  task automatic pulse(input bit tx);
    if (tx) tx_start = 1; else rx_start = 1;
    @(negedge clk);
    tx_start = 0; rx_start = 0;
  endtask

  task automatic wait_stop();
    @(negedge clk);
    while (tx_busy || rx_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic make_frame(input int f, input int len);
    for (int k = 0; k < len; k++) fr[f][k] = 8'($urandom);
  endtask

  task automatic send_rx(input int f, input int len, input logic [5:0] fl);
    for (int k = 0; k < len; k++) begin
      rx_valid = 1; rx_data = fr[f][k]; rx_last = (k == len - 1); rx_flags = fl;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 0; rx_last = 0; rx_flags = 0;
  endtask

  task automatic check_rx(input int i, input int f, input int len, input int blen,
                          input bit last, input logic [5:0] fl, input string req);
    logic [31:0] d = rx_ring_base + 32'(i * 16);
    int n = (len > blen) ? blen : len;
    int bad = -1;
    chk(mem[d[13:2] + 1] == {16'(blen), 16'(n)}, {req, " length word"}, mem[d[13:2] + 1], {16'(blen), 16'(n)});
    chk(mem[d[13:2]] == exp_rx_w0(last, len > blen, fl), {req, " status word R9"}, mem[d[13:2]],
        exp_rx_w0(last, len > blen, fl));
    for (int k = 0; k < n; k++)
      if (bad < 0 && rd_byte(RXB + 32'(i) * BUFSZ + 32'(k)) != fr[f][k]) bad = k;
    chk(bad < 0, {req, " stored bytes"}, bad, -1);
  endtask

  initial begin
    int l0, l1, l3, lc, le, la, lb;
    logic [5:0] fb;
    void'($urandom(32'd5150));
    for (int w = 0; w < 4096; w++) mem[w] = 32'hA5A5_A5A5;
    for (int k = 0; k < 4 * 1600; k++) wr_byte(TXB + 32'(k), 8'($urandom));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req && !tx_valid, "R1 memory/tx idle", {mem_req, tx_valid}, 0);
    chk(!tx_busy && !rx_busy, "R1 walkers stopped", {tx_busy, rx_busy}, 0);
    chk(!rx_ready && !rx_frame_done, "R1 receive idle", {rx_ready, rx_frame_done}, 0);

    // transmit: two frames, a zero-length one, stop at unowned desc 3
    l0 = 1 + $urandom % 120; l1 = 1 + $urandom % 120;
    tx_desc(0, 1, 0, l0); tx_desc(1, 1, 0, l1); tx_desc(2, 1, 0, 0); tx_desc(3, 0, 1, 0);
    expect_tx(0, l0); expect_tx(1, l1);
    pulse(1); wait_stop();
    check_tx("R2 frames 0,1 and empty 2");
    chk(mem[0] == tx_w0(0, 0), "R4 desc0 returned", mem[0], tx_w0(0, 0));
    chk(mem[8] == tx_w0(0, 0), "R4 empty desc2 returned", mem[8], tx_w0(0, 0));
    chk(mem[12] == tx_w0(0, 1), "R5 unowned desc3 untouched", mem[12], tx_w0(0, 1));
    chk(!tx_busy, "R5 busy dropped", tx_busy, 0);

    // resume at desc3 (last), wrap to desc0 with oversize length, stop at desc1
    l3 = 1 + $urandom % 60;
    tx_desc(3, 1, 1, l3); tx_desc(0, 1, 0, 1600);
    expect_tx(3, l3); expect_tx(0, 1600);
    pulse(1); wait_stop();
    check_tx("R3 R6 wrap and truncation");
    chk(mem[12] == tx_w0(0, 1), "R4 last bit kept on desc3", mem[12], tx_w0(0, 1));
    chk(mem[0] == tx_w0(0, 0), "R6 desc0 reached after wrap", mem[0], tx_w0(0, 0));

    // receive: two frames, second with random error flags
    rx_desc(0, 1, 0, 1600); rx_desc(1, 1, 0, 1600); rx_desc(2, 0, 0, 40); rx_desc(3, 0, 1, 1600);
    la = 1 + $urandom % 200; lb = 1 + $urandom % 200; fb = 6'($urandom) | 6'd1;
    make_frame(0, la); make_frame(1, lb);
    pulse(0);
    send_rx(0, la, 0); send_rx(1, lb, fb);
    wait_stop();
    check_rx(0, 0, la, 1600, 0, 0, "R7 frame A");
    check_rx(1, 1, lb, 1600, 0, fb, "R9 frame B flags");
    if (la % 4 != 0)
      chk(rd_byte(RXB + 32'(la | 3)) == 0, "R7 zero tail lane", rd_byte(RXB + 32'(la | 3)), 0);
    chk(pulses == 2, "R10 one pulse per frame", pulses, 2);

    // R11: nothing owned -> no acceptance
    rx_valid = 1; rx_data = 8'h3C;
    for (int c = 0; c < 20; c++) begin
      if (rx_ready) chk(0, "R11 rx_ready while stopped", rx_ready, 0);
      @(negedge clk);
    end
    rx_valid = 0;
    chk(!rx_ready && pulses == 2, "R11 stall held", pulses, 2);
    chk(mem[(32'h120) >> 2] == 32'h0, "R11 desc2 untouched", mem[(32'h120) >> 2], 0);

    // overflow into desc2 (40 bytes), then last desc3, re-arm desc0 for wrap
    rx_desc(2, 1, 0, 40); rx_desc(3, 1, 1, 1600); rx_desc(0, 1, 0, 1600);
    make_frame(2, 60); lc = 1 + $urandom % 100; make_frame(3, lc);
    pulse(0);
    send_rx(2, 60, 0);
    send_rx(3, lc, 6'b100000);
    repeat (40) @(negedge clk);
    check_rx(2, 2, 60, 40, 0, 0, "R8 overflow");
    chk(mem[(RXB + 2 * BUFSZ + 40) >> 2] == 32'hA5A5_A5A5, "R8 nothing past buffer",
        mem[(RXB + 2 * BUFSZ + 40) >> 2], 32'hA5A5_A5A5);
    check_rx(3, 3, lc, 1600, 1, 6'b100000, "R9 last bit kept");

    // concurrent: receive wraps into desc0 while transmit sends desc1
    le = 1 + $urandom % 200; make_frame(4, le);
    l1 = 1 + $urandom % 200;
    tx_desc(1, 1, 0, l1); expect_tx(1, l1);
    fork
      send_rx(4, le, 0);
      pulse(1);
    join
    wait_stop();
    check_rx(0, 4, le, 1600, 0, 0, "R12 R6 receive after wrap");
    check_tx("R12 transmit alongside receive");
    chk(pulses == 5, "R10 pulse total", pulses, 5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule